// File: doc/BRIEF.md
# Burst Column Address Generator

This block steps through the column addresses of one memory burst. A controller pulses a start strobe with the first column, a burst length code and a wrap order. From the next clock on, the block presents one column address per cycle with a valid flag. On the final beat it raises a last-beat flag, which the controller uses to close the burst or to launch a self-timed precharge.

Two wrap orders are available, and both stay inside the naturally aligned block of the burst length. Sequential order counts upward in the low address bits. Interleaved order XORs the beat number into the low bits. A full-page length runs around the whole row and stops only when the terminate input is asserted. A new start strobe can arrive on any clock and replaces the burst in progress. An illegal length/order combination falls back to eight beats and raises an error flag.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `valid_o`, `last_o` and `len_err_o` are low.
- R2: `start_i` high at a rising edge makes `valid_o` high one cycle later, with `col_o` equal to the sampled `start_col_i` (beat 0).
- R3: `len_code_i` values 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. `last_o` is high only on the final beat, and `valid_o` is low on the cycle after the final beat unless a new start was sampled.
- R4: When `wrap_il_i` = 0 (sequential), beat k presents `(S & ~M) | ((S + k) & M)`, where S is the start column and M = length − 1.
- R5: When `wrap_il_i` = 1 (interleaved), beat k presents `(S & ~M) | ((S ^ k) & M)`.
- R6: `len_code_i` = 7 with sequential order is full page. Beat k presents `(S + k) mod 2^COL_W`, so the burst wraps around the row, and it runs without a last beat until `stop_i` is asserted.
- R7: `stop_i` high while `valid_o` is high makes `last_o` high in that same cycle. Without a start, `valid_o` is low in the next cycle.
- R8: A start sampled while a burst is running begins the new burst on the next cycle. Start takes priority over `stop_i`.
- R9: Code 7 with interleaved order, and the reserved codes 4, 5 and 6, run as 8-beat bursts and set `len_err_o`. `len_err_o` is updated only at each start and holds its value until the next start.
- R10: While `valid_o` is low, `last_o` stays low and `stop_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst (preempts any running burst) |
| start_col_i | input | COL_W | First column of the burst |
| len_code_i | input | 3 | Burst length code: 0..3 = 1/2/4/8, 7 = full page, 4..6 reserved |
| wrap_il_i | input | 1 | Wrap order: 0 sequential, 1 interleaved |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | COL_W | Current column address |
| valid_o | output | 1 | `col_o` holds a burst beat |
| last_o | output | 1 | Current beat is the final one |
| len_err_o | output | 1 | Last start used an illegal length/order combination |

## Verification
Random bursts cover every length code under both wrap orders, with random start columns, so a misaligned start shows whether the upper bits stay fixed and the low bits wrap in the right order. Full-page bursts are run past 256 beats to separate a row-wide wrap from a block wrap. Directed cases cover preemption by a new start together with a stop, a stop on an idle block, and the reserved and illegal codes. The error flag is checked both on the beat and after the burst ends, so a flag that is not held is caught.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
   localparam logic [2:0] LEN_CODE_1    = 3'd0;
   localparam logic [2:0] LEN_CODE_2    = 3'd1;
   localparam logic [2:0] LEN_CODE_4    = 3'd2;
   localparam logic [2:0] LEN_CODE_8    = 3'd3;
   localparam logic [2:0] LEN_CODE_PAGE = 3'd7;

   typedef enum logic {
      WRAP_SEQ = 1'b0,
      WRAP_IL  = 1'b1
   } wrap_e;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
   import burst_col_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic [2:0]       code_i,
   input  wrap_e            wrap_i,
   output logic [COL_W-1:0] mask_o,
   output logic             full_o,
   output logic             err_o
);
   localparam logic [COL_W-1:0] MASK8 = COL_W'(7);

   always_comb begin
      full_o = 1'b0;
      err_o  = 1'b0;
      mask_o = MASK8;
      case (code_i)
         LEN_CODE_1: mask_o = '0;
         LEN_CODE_2: mask_o = COL_W'(1);
         LEN_CODE_4: mask_o = COL_W'(3);
         LEN_CODE_8: mask_o = MASK8;
         LEN_CODE_PAGE: begin
            if (wrap_i == WRAP_IL) begin
               err_o = 1'b1;
            end else begin
               mask_o = '1;
               full_o = 1'b1;
            end
         end
         default: err_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/burst_beat_ctl.sv
module burst_beat_ctl
   import burst_col_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  wrap_e            wrap_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             full_i,
   input  logic             err_i,
   input  logic             stop_i,
   output logic [COL_W-1:0] base_o,
   output logic [COL_W-1:0] mask_o,
   output logic [COL_W-1:0] beat_o,
   output wrap_e            wrap_o,
   output logic             valid_o,
   output logic             last_o,
   output logic             err_o
);
   logic             full_q;
   logic             final_beat;

   assign final_beat = !full_q && (beat_o == mask_o);
   assign last_o     = valid_o && (final_beat || stop_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_o  <= '0;
         mask_o  <= '0;
         beat_o  <= '0;
         wrap_o  <= WRAP_SEQ;
         full_q  <= 1'b0;
         valid_o <= 1'b0;
         err_o   <= 1'b0;
      end else if (start_i) begin
         base_o  <= start_col_i;
         mask_o  <= mask_i;
         beat_o  <= '0;
         wrap_o  <= wrap_i;
         full_q  <= full_i;
         valid_o <= 1'b1;
         err_o   <= err_i;
      end else if (valid_o) begin
         if (last_o) begin
            valid_o <= 1'b0;
         end else begin
            beat_o <= beat_o + COL_W'(1);
         end
      end
   end
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
   import burst_col_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic [COL_W-1:0] mask_i,
   input  wrap_e            wrap_i,
   output logic [COL_W-1:0] col_o
);
   logic [COL_W-1:0] sum;
   assign sum = base_i + beat_i;

   for (genvar b = 0; b < COL_W; b++) begin : g_bit
      logic wrapped;
      assign wrapped  = (wrap_i == WRAP_IL) ? (base_i[b] ^ beat_i[b]) : sum[b];
      assign col_o[b] = mask_i[b] ? wrapped : base_i[b];
   end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
   import burst_col_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [2:0]       len_code_i,
   input  logic             wrap_il_i,
   input  logic             stop_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o,
   output logic             len_err_o
);
   if (COL_W < 3) begin : g_bad_width
      $error("burst_col_gen: COL_W must be at least 3 to hold an 8-beat block");
   end

   wrap_e            wrap_in;
   wrap_e            wrap_q;
   logic [COL_W-1:0] dec_mask;
   logic             dec_full;
   logic             dec_err;
   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] mask_q;
   logic [COL_W-1:0] beat_q;

   assign wrap_in = wrap_il_i ? WRAP_IL : WRAP_SEQ;

   burst_len_decode #(.COL_W(COL_W)) u_decode (
      .code_i (len_code_i),
      .wrap_i (wrap_in),
      .mask_o (dec_mask),
      .full_o (dec_full),
      .err_o  (dec_err)
   );

   burst_beat_ctl #(.COL_W(COL_W)) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .start_col_i (start_col_i),
      .wrap_i      (wrap_in),
      .mask_i      (dec_mask),
      .full_i      (dec_full),
      .err_i       (dec_err),
      .stop_i      (stop_i),
      .base_o      (base_q),
      .mask_o      (mask_q),
      .beat_o      (beat_q),
      .wrap_o      (wrap_q),
      .valid_o     (valid_o),
      .last_o      (last_o),
      .err_o       (len_err_o)
   );

   burst_col_map #(.COL_W(COL_W)) u_map (
      .base_i (base_q),
      .beat_i (beat_q),
      .mask_i (mask_q),
      .wrap_i (wrap_q),
      .col_o  (col_o)
   );

   // R2: a sampled start shows its column on the next cycle
   assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (valid_o && col_o == $past(start_col_i)));

   // R4, R6: a sequential beat advances by one inside the block
   assert_seq_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !last_o && !start_i && wrap_q == WRAP_SEQ) |=>
      (col_o == ((($past(col_o) + COL_W'(1)) & mask_q) | ($past(col_o) & ~mask_q))));

   // R3, R7: the burst ends after its last beat
   assert_end_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && last_o && !start_i) |=> !valid_o);

   // R10: no last beat while idle
   assert_idle_no_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> !last_o);

   // R9: illegal full-page interleaved request flags an error
   assert_err_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && len_code_i == LEN_CODE_PAGE && wrap_il_i) |=> len_err_o);

   // R9: the error flag changes only at a start
   assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> $stable(len_err_o));
endmodule

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;
   localparam int COL_W = 8;
   localparam int ROW   = 1 << COL_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [COL_W-1:0] start_col_i = '0;
   logic [2:0]       len_code_i = '0;
   logic             wrap_il_i = 1'b0;
   logic             stop_i = 1'b0;
   logic [COL_W-1:0] col_o;
   logic             valid_o;
   logic             last_o;
   logic             len_err_o;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   burst_col_gen #(.COL_W(COL_W)) i_burst_col_gen (
      .clk, .rst_n, .start_i, .start_col_i, .len_code_i, .wrap_il_i, .stop_i,
      .col_o, .valid_o, .last_o, .len_err_o
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected below 100000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit is_err(input logic [2:0] code, input bit il);
      return (code > 3'd3 && code != 3'd7) || (code == 3'd7 && il);
   endfunction

   function automatic int exp_len(input logic [2:0] code, input bit il);
      if (code <= 3'd3) return 1 << code;
      if (code == 3'd7 && !il) return ROW;
      return 8;
   endfunction

   function automatic int exp_col(input int s, input int len, input bit il, input int k);
      int m = len - 1;
      if (il) return (s & ~m) | ((s ^ k) & m);
      return ((s & ~m) | ((s + k) & m)) & (ROW - 1);
   endfunction

   // stop_at < 0: no stop
   task automatic run_burst(input int s, input logic [2:0] code, input bit il,
                            input int stop_at, input string req);
      int  len  = exp_len(code, il);
      bit  full = (code == 3'd7) && !il;
      bit  done = 1'b0;
      @(negedge clk);
      start_i = 1'b1; start_col_i = COL_W'(s); len_code_i = code; wrap_il_i = il; stop_i = 1'b0;
      for (int k = 0; !done; k++) begin
         bit exp_last;
         @(negedge clk);
         start_i  = 1'b0;
         stop_i   = (k == stop_at);
         exp_last = (k == stop_at) || (!full && k == len - 1);
         #1;
         check({req, " valid"}, valid_o, 1);
         check({req, " col"}, col_o, exp_col(s, len, il, k));
         check({req, " last"}, last_o, exp_last);
         if (k == 0) check("R9 err flag on beat", len_err_o, is_err(code, il));
         done = exp_last;
      end
      @(negedge clk);
      stop_i = 1'b0;
      #1;
      check("R3 valid low after last", valid_o, 0);
      check("R9 err flag held", len_err_o, is_err(code, il));
   endtask

   initial begin
      void'($urandom(32'd4711));
      #1;
      check("R1 valid at reset", valid_o, 0);
      check("R1 last at reset", last_o, 0);
      check("R1 err at reset", len_err_o, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10: stop while idle has no effect
      @(negedge clk); stop_i = 1'b1; #1;
      check("R10 idle last", last_o, 0);
      @(negedge clk); stop_i = 1'b0; #1;
      check("R10 idle valid", valid_o, 0);

      // Directed lengths and orders
      run_burst(8'h25, 3'd0, 1'b0, -1, "R3 len1");
      run_burst(8'h25, 3'd1, 1'b1, -1, "R5 len2 il");
      run_burst(8'h2E, 3'd2, 1'b0, -1, "R4 len4 seq");
      run_burst(8'h2E, 3'd3, 1'b1, -1, "R5 len8 il");
      run_burst(8'h6D, 3'd3, 1'b0, -1, "R4 len8 seq");
      run_burst(8'hF0, 3'd7, 1'b0, 300, "R6 full page wrap");
      run_burst(8'h13, 3'd7, 1'b1, -1, "R9 page il as 8");
      run_burst(8'h13, 3'd5, 1'b0, -1, "R9 reserved code");
      run_burst(8'h42, 3'd3, 1'b0, 2, "R7 stop mid burst");
      run_burst(8'h42, 3'd1, 1'b0, -1, "R9 err cleared");

      // R8: preempt with simultaneous stop
      @(negedge clk);
      start_i = 1'b1; start_col_i = 8'h10; len_code_i = 3'd3; wrap_il_i = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         start_i = 1'b0;
         if (k == 2) begin
            start_i = 1'b1; stop_i = 1'b1;
            start_col_i = 8'h35; len_code_i = 3'd2; wrap_il_i = 1'b1;
         end
         #1;
         check("R8 first burst col", col_o, 8'h10 + k);
      end
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         start_i = 1'b0; stop_i = 1'b0;
         #1;
         check("R8 preempt valid", valid_o, 1);
         check("R8 preempt col", col_o, exp_col(8'h35, 4, 1'b1, k));
         check("R8 preempt last", last_o, k == 3);
      end
      @(negedge clk); #1;
      check("R8 preempt end", valid_o, 0);

      // Random bursts
      for (int n = 0; n < 200; n++) begin
         logic [2:0] code = 3'($urandom % 8);
         bit         il   = 1'($urandom % 2);
         int         s    = int'($urandom % ROW);
         int         len  = exp_len(code, il);
         int         sa   = -1;
         if (code == 3'd7 && !il) sa = int'($urandom % 300);
         else if ($urandom % 4 == 0) sa = int'($urandom % len);
         run_burst(s, code, il, sa, il ? "R5 random" : "R4 random");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule